// File: doc/BRIEF.md
# Compare Waveform Generator with Deferred Register Update

This block turns a free-running counter value into a digital waveform. It compares the counter against a compare threshold and a reload limit. The output is asserted while the counter lies above the threshold and does not exceed the limit. The counter and its period-end strobe come from a separate counter block. This block holds only the threshold and the limit, the output polarity, and the one-shot behaviour.

Writes to the threshold and the limit can take effect in one of two ways. They can apply on the next clock edge. They can also wait in a shadow copy until the next period-end strobe, so that a new duty cycle never starts partway through a period. In set-once mode, the first period end latches the output at its asserted level. The output then stays at that level until the block is disabled and enabled again. An inversion bit flips the output level in every mode. The output comes from a flip-flop, so it carries no combinational glitches.

Top module: `cmpwave_top`

## Requirements
- R1: While `rst` is high, the clock edge sets `wave_out` to 0, `cmp_active` to 0 and `arr_active` to all ones.
- R2: With `en`=1 and no set-once hold, `wave_out` becomes 1 one clock after `cmp_active < cnt_val <= arr_active` (with `pol_inv`=0).
- R3: With `pol_inv`=0 and no hold, `wave_out` becomes 0 one clock after `cnt_val <= cmp_active` or `cnt_val > arr_active`.
- R4: When `pol_inv`=1, the level on `wave_out` is the inverse of the level that R2, R3 and R8 would give.
- R5: With `preload`=0, the value written through `cmp_wr`/`cmp_wdata` or `arr_wr`/`arr_wdata` appears on `cmp_active`/`arr_active` after the next clock edge.
- R6: With `preload`=1, a write leaves the active value unchanged until a clock edge at which `period_end`=1, and that edge makes the written value active.
- R7: With `preload`=1, a write in the same cycle as `period_end`=1 becomes active at that edge.
- R8: With `set_once`=1 and `en`=1, the edge that sees `period_end`=1 arms a hold. From the following edge on, `wave_out` stays at the asserted level (1 before inversion), whatever the value of `cnt_val`.
- R9: With `en`=0, `wave_out` shows the inactive level (equal to `pol_inv`) one clock later, and the set-once hold is cleared.
- R10: With `preload`=1, only the last of several writes made before a period end becomes active. A period end that has no pending write leaves the active value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Output enable; a low level clears the set-once hold |
| pol_inv | input | 1 | Invert the output level |
| set_once | input | 1 | One-shot hold mode |
| preload | input | 1 | 1: writes wait for the period end; 0: writes apply at once |
| cnt_val | input | 16 | Counter value to compare |
| period_end | input | 1 | One-cycle strobe marking the end of a counter period |
| cmp_wr | input | 1 | Compare threshold write strobe |
| cmp_wdata | input | 16 | Compare threshold write data |
| arr_wr | input | 1 | Reload limit write strobe |
| arr_wdata | input | 16 | Reload limit write data |
| wave_out | output | 1 | Registered waveform output |
| cmp_active | output | 16 | Compare threshold currently in use |
| arr_active | output | 16 | Reload limit currently in use |

## Verification
The bench probes the window edges exactly, at the threshold, one above it, at the limit and one above it. A design with an off-by-one comparison shows the wrong level at exactly one of these points. For deferred updates, the bench writes twice before a strobe, issues a strobe with nothing pending, and writes in the same cycle as the strobe. A design that applies the first write, that clears the active value on an empty strobe, or that drops a coincident write shows a wrong active value. For set-once mode, the bench moves the counter outside the window after the hold is armed, then disables and re-enables the block. A design that keeps comparing or never clears the hold shows the wrong output level.

// File: rtl/cmpwave_pkg.sv
package cmpwave_pkg;

    typedef struct packed {
        logic pol_inv;
        logic set_once;
        logic preload;
    } wave_cfg_t;

    typedef enum logic [1:0] {
        WV_IDLE = 2'd0,
        WV_RUN  = 2'd1,
        WV_HELD = 2'd2
    } wave_state_t;

    function automatic logic apply_pol(input logic level, input logic inv);
        return level ^ inv;
    endfunction

endpackage

// File: rtl/cmpwave_shadow.sv
module cmpwave_shadow #(
    parameter int          W       = 16,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         preload,
    input  logic         period_end,
    input  logic         wr,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] active
);

    logic [W-1:0] shadow_q;
    logic         pending_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= RST_VAL;
            shadow_q  <= RST_VAL;
            pending_q <= 1'b0;
        end else if (!preload) begin
            if (wr) active <= wr_data;
            pending_q <= 1'b0;
        end else if (period_end) begin
            if (wr)             active <= wr_data;
            else if (pending_q) active <= shadow_q;
            pending_q <= 1'b0;
        end else if (wr) begin
            shadow_q  <= wr_data;
            pending_q <= 1'b1;
        end
    end

    AST_DIRECT_WRITE: assert property (@(posedge clk) disable iff (rst)
        (!preload && wr) |=> (active == $past(wr_data)));  // R5

    AST_DEFERRED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (preload && !period_end) |=> $stable(active));  // R6

    AST_COINCIDENT_WRITE: assert property (@(posedge clk) disable iff (rst)
        (preload && period_end && wr) |=> (active == $past(wr_data)));  // R7

endmodule

// File: rtl/cmpwave_gen.sv
module cmpwave_gen
    import cmpwave_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  wave_cfg_t    cfg,
    input  logic [W-1:0] cnt_val,
    input  logic [W-1:0] cmp_val,
    input  logic [W-1:0] arr_val,
    input  logic         period_end,
    output logic         wave_q
);

    wave_state_t state_q, state_d;
    logic        in_window;
    logic        held;

    assign in_window = (cnt_val > cmp_val) && (cnt_val <= arr_val);
    assign held      = (state_q == WV_HELD) && cfg.set_once;

    always_comb begin
        state_d = state_q;
        if (!en)
            state_d = WV_IDLE;
        else if (cfg.set_once && period_end)
            state_d = WV_HELD;
        else if (state_q != WV_HELD)
            state_d = WV_RUN;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WV_IDLE;
            wave_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (!en)
                wave_q <= apply_pol(1'b0, cfg.pol_inv);
            else if (held)
                wave_q <= apply_pol(1'b1, cfg.pol_inv);
            else
                wave_q <= apply_pol(in_window, cfg.pol_inv);
        end
    end

    AST_WINDOW_ASSERTED: assert property (@(posedge clk) disable iff (rst)
        (en && !cfg.set_once && cnt_val > cmp_val && cnt_val <= arr_val)
        |=> (wave_q == !$past(cfg.pol_inv)));  // R2

    AST_OUTSIDE_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (en && !cfg.set_once && (cnt_val <= cmp_val || cnt_val > arr_val))
        |=> (wave_q == $past(cfg.pol_inv)));  // R3

    AST_SET_ONCE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (en && cfg.set_once && period_end) ##1 (en && cfg.set_once)
        |=> (wave_q == !$past(cfg.pol_inv)));  // R8

    AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (rst)
        !en |=> (wave_q == $past(cfg.pol_inv)));  // R9

endmodule

// File: rtl/cmpwave_top.sv
module cmpwave_top
    import cmpwave_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             pol_inv,
    input  logic             set_once,
    input  logic             preload,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             period_end,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             arr_wr,
    input  logic [CNT_W-1:0] arr_wdata,
    output logic             wave_out,
    output logic [CNT_W-1:0] cmp_active,
    output logic [CNT_W-1:0] arr_active
);

    localparam logic [CNT_W-1:0] CMP_RST = '0;
    localparam logic [CNT_W-1:0] ARR_RST = '1;

    wave_cfg_t cfg;
    assign cfg = '{pol_inv: pol_inv, set_once: set_once, preload: preload};

    cmpwave_shadow #(.W(CNT_W), .RST_VAL(CMP_RST)) i_cmp_reg (
        .clk        (clk),
        .rst        (rst),
        .preload    (cfg.preload),
        .period_end (period_end),
        .wr         (cmp_wr),
        .wr_data    (cmp_wdata),
        .active     (cmp_active)
    );

    cmpwave_shadow #(.W(CNT_W), .RST_VAL(ARR_RST)) i_arr_reg (
        .clk        (clk),
        .rst        (rst),
        .preload    (cfg.preload),
        .period_end (period_end),
        .wr         (arr_wr),
        .wr_data    (arr_wdata),
        .active     (arr_active)
    );

    cmpwave_gen #(.W(CNT_W)) i_gen (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .cfg        (cfg),
        .cnt_val    (cnt_val),
        .cmp_val    (cmp_active),
        .arr_val    (arr_active),
        .period_end (period_end),
        .wave_q     (wave_out)
    );

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (wave_out == 1'b0 && cmp_active == CMP_RST && arr_active == ARR_RST));  // R1

endmodule

// File: tb/test_cmpwave_top.sv
module test_cmpwave_top;

    logic        clk = 1'b0;
    logic        rst, en, pol_inv, set_once, preload, period_end;
    logic [15:0] cnt_val, cmp_wdata, arr_wdata;
    logic        cmp_wr, arr_wr;
    logic        wave_out;
    logic [15:0] cmp_active, arr_active;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    cmpwave_top i_cmpwave_top (
        .clk(clk), .rst(rst), .en(en), .pol_inv(pol_inv), .set_once(set_once),
        .preload(preload), .cnt_val(cnt_val), .period_end(period_end),
        .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .arr_wr(arr_wr),
        .arr_wdata(arr_wdata), .wave_out(wave_out), .cmp_active(cmp_active),
        .arr_active(arr_active)
    );

    typedef struct packed {
        logic [15:0] cnt;
        logic        pol;
        logic        exp;
    } vec_t;

    // compare window: threshold 100, limit 200
    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{16'd50,    1'b0, 1'b0},
        '{16'd100,   1'b0, 1'b0},
        '{16'd101,   1'b0, 1'b1},
        '{16'd150,   1'b0, 1'b1},
        '{16'd200,   1'b0, 1'b1},
        '{16'd201,   1'b0, 1'b0},
        '{16'd65535, 1'b0, 1'b0},
        '{16'd0,     1'b0, 1'b0},
        '{16'd150,   1'b1, 1'b0},
        '{16'd100,   1'b1, 1'b1},
        '{16'd201,   1'b1, 1'b1},
        '{16'd200,   1'b1, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; en = 1'b1; pol_inv = 1'b0; set_once = 1'b0; preload = 1'b0;
        period_end = 1'b0; cnt_val = 16'd0; cmp_wr = 1'b0; arr_wr = 1'b0;
        cmp_wdata = 16'd0; arr_wdata = 16'd0;
        @(negedge clk);
        step();
        check("R1 wave", {31'd0, wave_out}, 32'd0);
        check("R1 cmp", {16'd0, cmp_active}, 32'd0);
        check("R1 arr", {16'd0, arr_active}, 32'h0000FFFF);
        rst = 1'b0;

        // R5: immediate writes
        cmp_wr = 1'b1; cmp_wdata = 16'd100; arr_wr = 1'b1; arr_wdata = 16'd200;
        step();
        cmp_wr = 1'b0; arr_wr = 1'b0;
        check("R5 cmp", {16'd0, cmp_active}, 32'd100);
        check("R5 arr", {16'd0, arr_active}, 32'd200);

        // R2 R3 R4: vector table
        for (int i = 0; i < NV; i++) begin
            cnt_val = VECS[i].cnt; pol_inv = VECS[i].pol;
            step();
            check(VECS[i].pol ? "R4 window" : (VECS[i].exp ? "R2 window" : "R3 window"),
                  {31'd0, wave_out}, {31'd0, VECS[i].exp});
        end
        pol_inv = 1'b0;

        // R6 R10: deferred writes, last wins
        preload = 1'b1;
        cmp_wr = 1'b1; cmp_wdata = 16'd30;
        step();
        check("R6 no early update", {16'd0, cmp_active}, 32'd100);
        cmp_wdata = 16'd40;
        step();
        cmp_wr = 1'b0;
        step();
        check("R6 still held", {16'd0, cmp_active}, 32'd100);
        period_end = 1'b1;
        step();
        period_end = 1'b0;
        check("R10 last write wins", {16'd0, cmp_active}, 32'd40);
        period_end = 1'b1;
        step();
        period_end = 1'b0;
        check("R10 empty strobe", {16'd0, cmp_active}, 32'd40);

        // R7: write coincident with strobe
        arr_wr = 1'b1; arr_wdata = 16'd300; period_end = 1'b1;
        step();
        arr_wr = 1'b0; period_end = 1'b0;
        check("R7 coincident", {16'd0, arr_active}, 32'd300);

        // restore window 100..200 immediately
        preload = 1'b0;
        cmp_wr = 1'b1; cmp_wdata = 16'd100; arr_wr = 1'b1; arr_wdata = 16'd200;
        step();
        cmp_wr = 1'b0; arr_wr = 1'b0;
        check("R5 restore", {16'd0, cmp_active}, 32'd100);

        // R8: set-once hold
        set_once = 1'b1; cnt_val = 16'd50;
        step();
        check("R8 before hold", {31'd0, wave_out}, 32'd0);
        period_end = 1'b1;
        step();
        period_end = 1'b0;
        step();
        check("R8 held low cnt", {31'd0, wave_out}, 32'd1);
        cnt_val = 16'd250;
        step();
        check("R8 held high cnt", {31'd0, wave_out}, 32'd1);
        pol_inv = 1'b1;
        step();
        check("R4 held inverted", {31'd0, wave_out}, 32'd0);

        // R9: disable, then re-enable clears hold
        en = 1'b0;
        step();
        check("R9 idle inverted", {31'd0, wave_out}, 32'd1);
        pol_inv = 1'b0;
        step();
        check("R9 idle", {31'd0, wave_out}, 32'd0);
        en = 1'b1; cnt_val = 16'd50;
        step();
        check("R9 hold cleared", {31'd0, wave_out}, 32'd0);
        cnt_val = 16'd150;
        step();
        check("R2 after re-enable", {31'd0, wave_out}, 32'd1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule